// File: doc/BRIEF.md
# Start-Bit Framed Serial Transmitter

This block serialises bytes onto a single data line, one bit per clock, for a synchronous link where transmitter and receiver share the clock. A byte is handed over on a parallel input with a valid strobe. It goes out as one high start bit followed by the data bits, least significant first. When nothing is being sent the line rests low. There is no stop bit, so the receiver finds each byte by the start bit alone.

The accepted byte is copied into an internal frame register, so the source is free as soon as the byte is taken. The busy output drops during the last data bit. That lets a byte presented in that cycle be loaded right away, and its start bit follows the previous byte's last bit with no idle cycle. The line then carries one byte every nine clocks.

Top module: `sync_frame_tx`

## Requirements
- R1: While no frame is in progress and no byte was accepted at the previous clock edge, ser_o is 0.
- R2: A byte is accepted at a rising clock edge where valid_i is 1 and busy_o is 0. In the cycle after that edge, ser_o is 1 (the start bit).
- R3: In the eight cycles after the start bit, ser_o carries data bit 0, then bit 1, and so on up to bit 7 of the accepted byte, one bit per cycle.
- R4: A frame occupies exactly nine cycles on the line. If no byte is accepted at the edge that ends bit 7, ser_o returns to 0.
- R5: A byte presented with valid_i high during the bit 7 cycle is accepted. Its start bit appears in the next cycle, giving a gapless nine-cycle byte period.
- R6: busy_o is 1 for exactly eight cycles per frame, from the start bit through bit 6, and is 0 during bit 7.
- R7: valid_i and data_i are ignored while busy_o is 1. The frame in progress is not altered, and no extra frame is sent afterwards.
- R8: Changing data_i after acceptance does not change the bits sent.
- R9: While rst_ni is 0, ser_o and busy_o are 0, including when reset is asserted in the middle of a frame. No byte is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one line bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | DATA_W | Byte to transmit |
| valid_i | input | 1 | Byte on data_i is offered |
| busy_o | output | 1 | Frame in progress; high means offers are not taken |
| ser_o | output | 1 | Serial data line |

## Verification
The assertions check, on every cycle, that an accepted byte is always followed by a start bit with busy raised. They also check that every busy run lasts exactly eight cycles and that the line stays low whenever no frame is active. Only the bench can show the data bits themselves: their order and their values for every one of the 256 bytes. The bench also shows back-to-back framing without a gap, that offers made while busy are ignored, that changes to data_i after acceptance have no effect, and that a reset in the middle of a frame leaves nothing pending.

// File: rtl/sync_frame_tx_pkg.sv
package sync_frame_tx_pkg;
  localparam int unsigned START_BITS = 1;

  function automatic int unsigned frame_len(input int unsigned data_w);
    return data_w + START_BITS;
  endfunction
endpackage

// File: rtl/sync_frame_tx_seq.sv
module sync_frame_tx_seq
  import sync_frame_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic load_o,
  output logic busy_o
);
  localparam int unsigned LOAD_CNT = frame_len(DATA_W) - 1;

  // cnt_q holds the bits remaining after the one on the line; 0 = bit 7 or idle
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign load_o = valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_o)     cnt_q <= CNT_W'(LOAD_CNT);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sync_frame_tx_shift.sv
module sync_frame_tx_shift
  import sync_frame_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned FRM_W = frame_len(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_o
);
  logic [FRM_W-1:0] frm_q;

  // start bit in bit 0; zeros shifted in keep the line low after the frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frm_q <= '0;
    else if (load_i) frm_q <= {data_i, 1'b1};
    else             frm_q <= {1'b0, frm_q[FRM_W-1:1]};
  end

  assign ser_o = frm_q[0];
endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              busy_o,
  output logic              ser_o
);
  logic load;

  sync_frame_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .load_o (load),
    .busy_o (busy_o)
  );

  sync_frame_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .data_i(data_i),
    .ser_o (ser_o)
  );
endmodule

// File: rtl/sync_frame_tx_chk.sv
module sync_frame_tx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic busy_o,
  input logic ser_o
);
  localparam int unsigned RUN_LEN = DATA_W;
  localparam int unsigned RUN_W   = $clog2(DATA_W + 2);

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r2_start_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !busy_o) |=> (ser_o && busy_o));

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(valid_i && !busy_o)) |-> !ser_o);

  a_r6_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == RUN_W'(RUN_LEN)));

  a_r6_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < RUN_W'(RUN_LEN)));
endmodule

bind sync_frame_tx sync_frame_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .busy_o (busy_o),
  .ser_o  (ser_o)
);

// File: tb/sync_frame_tx_test.sv
module sync_frame_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = 8'h00;
  logic       valid = 1'b0;
  logic       busy, ser;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_frame_tx #(.DATA_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .busy_o(busy), .ser_o(ser)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Entered just after a negedge with busy low; returns at the bit 7 negedge.
  task automatic send(input logic [7:0] b, input bit junk);
    valid = 1'b1; data = b;
    @(negedge clk);
    chk("R2 start bit", ser, 1'b1);
    chk("R6 busy at start", busy, 1'b1);
    data = ~b;                     // R8: source changes after acceptance
    valid = junk;                  // R7: offers while busy
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R3 data bit", ser, b[i]);
      chk("R6 busy per bit", busy, (i != 7));
      valid = junk && (i < 6);
      data = b ^ 8'(i * 37 + 5);
    end
    valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R4 line low after frame", ser, 1'b0);
      chk("R1 idle busy", busy, 1'b0);
    end
  endtask

  initial begin
    valid = 1'b1; data = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 reset ser", ser, 1'b0);
    chk("R9 reset busy", busy, 1'b0);
    valid = 1'b0;
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 idle line", ser, 1'b0);
    end
    for (int v = 0; v < 256; v++) begin
      send(8'(v), (v % 3) == 2);
      case (v % 4)
        0: ;                       // R5: next byte offered during bit 7
        1: idle(1);
        2: idle(3);
        default: ;
      endcase
    end
    idle(2);
    // R9: reset in the middle of a frame
    valid = 1'b1; data = 8'hA5;
    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 mid-frame reset ser", ser, 1'b0);
    chk("R9 mid-frame reset busy", busy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R9 nothing pending after reset", ser, 1'b0);
      chk("R9 busy after reset", busy, 1'b0);
    end
    send(8'h3C, 1'b0);
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule